// File: doc/BRIEF.md
# Biphasic Stimulation Pulse Sequencer with Active Charge Balancing

This block drives one stimulation channel through a train of biphasic pulses. A trigger starts the train. Each biphasic pulse has a first phase of configurable polarity, an interphase gap and a second phase of the opposite polarity. All three intervals are measured in high-frequency pulse slots granted by an upstream arbiter, not in clock cycles. When several channels share one pulse generator, each phase therefore stretches in time but always carries exactly its configured number of pulses.

After the second phase the block balances charge. It asks for the sign of the residual charge and injects one pulse of the opposite sign. It then senses again and keeps injecting while the sign still matches the first reading. Balancing ends on the first reading that differs, or after `BAL_MAX` injections; the second case sets an error flag. The train then moves to its next biphasic pulse, or finishes and raises `done` for one cycle. A stop request ends the train early: any pulse already requested is delivered first, and no balancing follows.

The pulse interface is a valid/ready pair. `pulse_req` is the valid signal and `polarity` is its payload. `pulse_grant` is the ready signal, or slot strobe, from the arbiter. A pulse is delivered in every cycle where both are high. Once `pulse_req` rises, it and `polarity` stay unchanged until a grant arrives, so the arbiter may stall the block for any number of cycles. Grant strobes that arrive while `pulse_req` is low are slots that pass unused. Only the interphase gap counts these slots.

Top module: `stim_biphase_seq`

## Requirements
- R1: After reset, `pulse_req`, `sense_req`, `done` and `bal_err` are all low. In idle the block makes no request until `trigger` is sampled high. A trigger that arrives while a train is running is ignored.
- R2: A pulse is delivered in each cycle where `pulse_req` and `pulse_grant` are both high. `polarity` is 1 for a cathodic pulse and 0 for an anodic pulse. Once `pulse_req` is high without a grant, it and `polarity` hold their values into the next cycle.
- R3: The first phase delivers exactly `cfg_phase1_len` pulses, with polarity equal to `cfg_first_cath`. A length of 0 skips the phase.
- R4: The interphase gap lasts `cfg_ipd_len` grant strobes that arrive while `pulse_req` is low. With a grant in every cycle and both phases non-empty, the first second-phase pulse comes `cfg_ipd_len + 3` cycles after the last first-phase pulse.
- R5: The second phase delivers exactly `cfg_phase2_len` pulses, with polarity opposite to `cfg_first_cath`.
- R6: After the second phase, `sense_req` goes high for one cycle, and `resid_neg` is sampled in that same cycle (1 means the residual charge is negative). One pulse of the opposite sign follows: polarity 0 when the first reading was 1, polarity 1 otherwise. Sensing and injection alternate while each new reading equals the first one. Balancing ends on the first reading that differs.
- R7: If `BAL_MAX` (255) injections are delivered without the sign changing, balancing ends with no further sense. `bal_err` then goes high, stays high until the next accepted trigger, and the train continues.
- R8: A train contains `cfg_trains` biphasic pulses, and a value of 0 counts as 1. `done` is high for exactly one cycle after the last balancing.
- R9: A stop request in mid-train returns the block to idle. A pulse that is already requested is delivered first, neither balancing nor `done` follows, and `pulse_req` stays low afterwards.
- R10: All configuration inputs are captured at the accepted trigger. Changing them during a train has no effect on that train.
- R11: `sense_req` and `pulse_req` are never high together, and neither is high while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_first_cath | input | 1 | First phase polarity: 1 = cathodic, 0 = anodic |
| cfg_phase1_len | input | LEN_W | First phase length in pulses |
| cfg_ipd_len | input | LEN_W | Interphase gap in grant slots |
| cfg_phase2_len | input | LEN_W | Second phase length in pulses |
| cfg_trains | input | TRAIN_W | Biphasic pulses per train (0 counts as 1) |
| trigger | input | 1 | Start a train when idle |
| stop | input | 1 | End the running train early |
| pulse_req | output | 1 | Pulse valid |
| pulse_grant | input | 1 | Pulse ready / slot strobe from the arbiter |
| polarity | output | 1 | Payload of the pulse request: 1 = cathodic |
| sense_req | output | 1 | Residual-sign sample strobe |
| resid_neg | input | 1 | Residual charge sign, valid while `sense_req` is high |
| done | output | 1 | One-cycle end-of-train strobe |
| bal_err | output | 1 | Balancing hit the injection cap |

## Verification
The bench sweeps phase lengths of 0 to 2, both first polarities, one or two biphasic pulses, and balancing that flips after one or two injections. It runs each case under arbiter grant rates of every cycle, every second cycle and every third cycle, and compares the full ordered list of pulses and senses against a list built arithmetically. This sweep would expose a design that counts phases in clock cycles, because stretched phases would carry the wrong number of pulses. It would also expose one that mishandles zero-length phases, which would show up as stray pulses, and one that mixes up injection polarity or stops balancing a step early or late. Directed cases cover:
- the interphase cycle gap, which an off-by-one counter would shift;
- the injection cap, where a design that counted wrong would inject 254 or 256 pulses or never raise the error flag;
- stop while a request is stalled, where a design that dropped the request or kept balancing would deliver the wrong number of pulses;
- a retrigger and configuration change mid-train, which would corrupt the pulse list or produce a second `done`.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PH1,
    ST_IPD,
    ST_PH2,
    ST_SENSE,
    ST_INJ,
    ST_NEXT
  } seq_state_t;
endpackage

// File: rtl/sbp_slot_counter.sv
// Counts qualified events and flags equality with a target value.
module sbp_slot_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] target,
  output logic         hit
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (inc) cnt_q <= cnt_q + W'(1);
  end

  assign hit = (cnt_q == target);
endmodule

// File: rtl/sbp_cfg_shadow.sv
// Holds the channel setup captured when a train is accepted.
module sbp_cfg_shadow #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             in_first_cath,
  input  logic [LEN_W-1:0] in_p1,
  input  logic [LEN_W-1:0] in_ipd,
  input  logic [LEN_W-1:0] in_p2,
  output logic             first_cath,
  output logic [LEN_W-1:0] p1_len,
  output logic [LEN_W-1:0] ipd_len,
  output logic [LEN_W-1:0] p2_len
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_cath <= 1'b0;
      p1_len     <= '0;
      ipd_len    <= '0;
      p2_len     <= '0;
    end else if (load) begin
      first_cath <= in_first_cath;
      p1_len     <= in_p1;
      ipd_len    <= in_ipd;
      p2_len     <= in_p2;
    end
  end
endmodule

// File: rtl/sbp_seq_fsm.sv
// Sequencing state machine: phases, gap, balancing loop, train count.
module sbp_seq_fsm
  import sbp_pkg::*;
#(
  parameter int LEN_W   = 8,
  parameter int TRAIN_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trigger,
  input  logic               stop,
  input  logic               pulse_grant,
  input  logic               resid_neg,
  input  logic [TRAIN_W-1:0] raw_trains,
  input  logic               first_cath,
  input  logic [LEN_W-1:0]   p1_len,
  input  logic [LEN_W-1:0]   ipd_len,
  input  logic [LEN_W-1:0]   p2_len,
  input  logic               ph_hit,
  input  logic               bal_hit,
  output logic               cfg_load,
  output logic               ph_clr,
  output logic               ph_inc,
  output logic [LEN_W-1:0]   ph_target,
  output logic               bal_clr,
  output logic               bal_inc,
  output logic               pulse_req,
  output logic               polarity,
  output logic               sense_req,
  output logic               done,
  output logic               bal_err
);
  seq_state_t         state_q, state_d;
  logic [TRAIN_W-1:0] trains_q, trains_d;
  logic               ref_q, ref_d;
  logic               first_q, first_d;
  logic               err_q, err_d;
  logic               done_q, done_d;
  logic               stop_pend_q, stop_pend_d;
  logic               stop_now;

  assign stop_now = stop | stop_pend_q;

  always_comb begin
    state_d  = state_q;
    trains_d = trains_q;
    ref_d    = ref_q;
    first_d  = first_q;
    err_d    = err_q;
    done_d   = 1'b0;
    cfg_load = 1'b0;
    ph_clr   = 1'b0;
    ph_inc   = 1'b0;
    bal_clr  = 1'b0;
    bal_inc  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (trigger) begin
          cfg_load = 1'b1;
          ph_clr   = 1'b1;
          err_d    = 1'b0;
          trains_d = (raw_trains == '0) ? TRAIN_W'(1) : raw_trains;
          state_d  = ST_PH1;
        end
      end
      ST_PH1: begin
        if (ph_hit) begin
          ph_clr  = 1'b1;
          state_d = stop_now ? ST_IDLE : ST_IPD;
        end else if (pulse_grant) begin
          ph_inc = 1'b1;
          if (stop_now) state_d = ST_IDLE;
        end
      end
      ST_IPD: begin
        if (stop_now) begin
          state_d = ST_IDLE;
        end else if (ph_hit) begin
          ph_clr  = 1'b1;
          state_d = ST_PH2;
        end else if (pulse_grant) begin
          ph_inc = 1'b1;
        end
      end
      ST_PH2: begin
        if (ph_hit) begin
          bal_clr = 1'b1;
          first_d = 1'b1;
          state_d = stop_now ? ST_IDLE : ST_SENSE;
        end else if (pulse_grant) begin
          ph_inc = 1'b1;
          if (stop_now) state_d = ST_IDLE;
        end
      end
      ST_SENSE: begin
        if (stop_now) begin
          state_d = ST_IDLE;
        end else if (first_q) begin
          ref_d   = resid_neg;
          first_d = 1'b0;
          state_d = ST_INJ;
        end else if (resid_neg != ref_q) begin
          state_d = ST_NEXT;
        end else begin
          state_d = ST_INJ;
        end
      end
      ST_INJ: begin
        if (pulse_grant) begin
          bal_inc = 1'b1;
          if (stop_now) begin
            state_d = ST_IDLE;
          end else if (bal_hit) begin
            err_d   = 1'b1;
            state_d = ST_NEXT;
          end else begin
            state_d = ST_SENSE;
          end
        end
      end
      ST_NEXT: begin
        if (stop_now) begin
          state_d = ST_IDLE;
        end else if (trains_q == TRAIN_W'(1)) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          trains_d = trains_q - TRAIN_W'(1);
          ph_clr   = 1'b1;
          state_d  = ST_PH1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    stop_pend_d = (state_d != ST_IDLE) && (stop_pend_q || stop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      trains_q    <= '0;
      ref_q       <= 1'b0;
      first_q     <= 1'b0;
      err_q       <= 1'b0;
      done_q      <= 1'b0;
      stop_pend_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      trains_q    <= trains_d;
      ref_q       <= ref_d;
      first_q     <= first_d;
      err_q       <= err_d;
      done_q      <= done_d;
      stop_pend_q <= stop_pend_d;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_PH1:  ph_target = p1_len;
      ST_IPD:  ph_target = ipd_len;
      ST_PH2:  ph_target = p2_len;
      default: ph_target = '0;
    endcase
  end

  always_comb begin
    unique case (state_q)
      ST_PH1:  polarity = first_cath;
      ST_PH2:  polarity = ~first_cath;
      ST_INJ:  polarity = ~ref_q;
      default: polarity = 1'b0;
    endcase
  end

  assign pulse_req = (((state_q == ST_PH1) || (state_q == ST_PH2)) && !ph_hit)
                     || (state_q == ST_INJ);
  assign sense_req = (state_q == ST_SENSE);
  assign done      = done_q;
  assign bal_err   = err_q;
endmodule

// File: rtl/stim_biphase_seq.sv
module stim_biphase_seq #(
  parameter int LEN_W   = 8,
  parameter int TRAIN_W = 8,
  parameter int BAL_MAX = 255
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_first_cath,
  input  logic [LEN_W-1:0]   cfg_phase1_len,
  input  logic [LEN_W-1:0]   cfg_ipd_len,
  input  logic [LEN_W-1:0]   cfg_phase2_len,
  input  logic [TRAIN_W-1:0] cfg_trains,
  input  logic               trigger,
  input  logic               stop,
  output logic               pulse_req,
  input  logic               pulse_grant,
  output logic               polarity,
  output logic               sense_req,
  input  logic               resid_neg,
  output logic               done,
  output logic               bal_err
);
  localparam int BAL_W = $clog2(BAL_MAX + 1);
  localparam logic [BAL_W-1:0] BAL_LAST = BAL_W'(BAL_MAX - 1);

  logic             cfg_load, ph_clr, ph_inc, ph_hit;
  logic             bal_clr, bal_inc, bal_hit;
  logic [LEN_W-1:0] ph_target;
  logic             sh_first;
  logic [LEN_W-1:0] sh_p1, sh_ipd, sh_p2;

  sbp_cfg_shadow #(.LEN_W(LEN_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(cfg_load),
    .in_first_cath(cfg_first_cath), .in_p1(cfg_phase1_len),
    .in_ipd(cfg_ipd_len), .in_p2(cfg_phase2_len),
    .first_cath(sh_first), .p1_len(sh_p1), .ipd_len(sh_ipd), .p2_len(sh_p2)
  );

  sbp_slot_counter #(.W(LEN_W)) u_phase_cnt (
    .clk(clk), .rst_n(rst_n), .clr(ph_clr), .inc(ph_inc),
    .target(ph_target), .hit(ph_hit)
  );

  sbp_slot_counter #(.W(BAL_W)) u_bal_cnt (
    .clk(clk), .rst_n(rst_n), .clr(bal_clr), .inc(bal_inc),
    .target(BAL_LAST), .hit(bal_hit)
  );

  sbp_seq_fsm #(.LEN_W(LEN_W), .TRAIN_W(TRAIN_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .trigger(trigger), .stop(stop),
    .pulse_grant(pulse_grant), .resid_neg(resid_neg), .raw_trains(cfg_trains),
    .first_cath(sh_first), .p1_len(sh_p1), .ipd_len(sh_ipd), .p2_len(sh_p2),
    .ph_hit(ph_hit), .bal_hit(bal_hit), .cfg_load(cfg_load),
    .ph_clr(ph_clr), .ph_inc(ph_inc), .ph_target(ph_target),
    .bal_clr(bal_clr), .bal_inc(bal_inc), .pulse_req(pulse_req),
    .polarity(polarity), .sense_req(sense_req), .done(done), .bal_err(bal_err)
  );
endmodule

// File: rtl/stim_biphase_seq_chk.sv
module stim_biphase_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic pulse_req,
  input logic pulse_grant,
  input logic polarity,
  input logic sense_req,
  input logic done,
  input logic bal_err
);
  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_req && !pulse_grant) |=> (pulse_req && $stable(polarity)));

  // R11
  req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pulse_req && sense_req));

  // R11
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!pulse_req && !sense_req));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bal_err) |-> $past(pulse_req && pulse_grant));
endmodule

bind stim_biphase_seq stim_biphase_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pulse_req(pulse_req), .pulse_grant(pulse_grant),
  .polarity(polarity), .sense_req(sense_req), .done(done), .bal_err(bal_err)
);

// File: tb/stim_biphase_seq_test.sv
module stim_biphase_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_first_cath = 1'b0;
  logic [7:0] cfg_phase1_len = '0, cfg_ipd_len = '0, cfg_phase2_len = '0, cfg_trains = '0;
  logic       trigger = 1'b0, stop = 1'b0, pulse_grant = 1'b0, resid_neg = 1'b0;
  logic       pulse_req, polarity, sense_req, done, bal_err;

  int checks = 0, errors = 0;
  int cyc = 0, gdiv = 0, kflip = 0, s0 = 0, sidx = 0;
  int ev [0:1023];
  int ev_cyc [0:1023];
  int ev_n = 0, done_cnt = 0, overlap = 0;
  int ex [0:1023];
  int ex_n = 0;

  stim_biphase_seq uut (
    .clk(clk), .rst_n(rst_n), .cfg_first_cath(cfg_first_cath),
    .cfg_phase1_len(cfg_phase1_len), .cfg_ipd_len(cfg_ipd_len),
    .cfg_phase2_len(cfg_phase2_len), .cfg_trains(cfg_trains),
    .trigger(trigger), .stop(stop), .pulse_req(pulse_req),
    .pulse_grant(pulse_grant), .polarity(polarity), .sense_req(sense_req),
    .resid_neg(resid_neg), .done(done), .bal_err(bal_err)
  );

  always #2 clk = ~clk;

  // Arbiter, residual model and event monitor, all away from the active edge.
  always @(negedge clk) begin
    cyc = cyc + 1;
    pulse_grant = (gdiv != 0) && ((cyc % (gdiv == 0 ? 1 : gdiv)) == 0);
    if (sense_req) begin
      resid_neg = (sidx <= kflip) ? s0[0] : ~s0[0];
      if (sidx == kflip + 1) sidx = 0;
      else sidx = sidx + 1;
    end
    if (rst_n) begin
      if (pulse_req && sense_req) overlap = overlap + 1;
      if (pulse_req && pulse_grant && ev_n < 1024) begin
        ev[ev_n] = polarity ? 1 : 0; ev_cyc[ev_n] = cyc; ev_n = ev_n + 1;
      end
      if (sense_req && ev_n < 1024) begin
        ev[ev_n] = 2; ev_cyc[ev_n] = cyc; ev_n = ev_n + 1;
      end
      if (done) done_cnt = done_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int v);
    ex[ex_n] = v; ex_n = ex_n + 1;
  endtask

  // Expected event list: 0 anodic pulse, 1 cathodic pulse, 2 sense.
  task automatic build(input int fc, input int p1, input int p2, input int tr, input int k, input int sg);
    int ntr;
    ex_n = 0;
    ntr = (tr == 0) ? 1 : tr;
    for (int t = 0; t < ntr; t++) begin
      for (int i = 0; i < p1; i++) push(fc);
      for (int i = 0; i < p2; i++) push(1 - fc);
      if (k >= 255) begin
        for (int i = 0; i < 255; i++) begin push(2); push(1 - sg); end
      end else begin
        push(2);
        for (int i = 0; i <= k; i++) begin push(1 - sg); push(2); end
      end
    end
  endtask

  task automatic start(input int fc, input int p1, input int ipd, input int p2, input int tr);
    cfg_first_cath = fc[0];
    cfg_phase1_len = 8'(p1); cfg_ipd_len = 8'(ipd);
    cfg_phase2_len = 8'(p2); cfg_trains = 8'(tr);
    ev_n = 0; done_cnt = 0; sidx = 0;
    @(negedge clk); trigger = 1'b1;
    @(negedge clk); trigger = 1'b0;
  endtask

  task automatic wait_done(input int limit);
    for (int i = 0; i < limit && done_cnt == 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic compare(input string req);
    int bad;
    bad = -1;
    for (int i = 0; i < ex_n; i++) if (bad < 0 && (i >= ev_n || ev[i] != ex[i])) bad = i;
    check(ev_n == ex_n, req, ev_n, ex_n);
    if (bad >= 0) check(1'b0, req, (bad < ev_n) ? ev[bad] : -1, ex[bad]);
    else check(1'b1, req, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!pulse_req && !sense_req && !done && !bal_err, "R1 reset outputs",
          {pulse_req, sense_req, done, bal_err}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!pulse_req && !sense_req, "R1 idle without trigger", pulse_req, 0);

    // R3 R5 R6 R8 R2: sweep over a small configuration and grant rates
    for (int g = 1; g <= 3; g++)
      for (int fc = 0; fc < 2; fc++)
        for (int p1 = 0; p1 <= 2; p1++)
          for (int p2 = 0; p2 <= 2; p2++)
            for (int ipd = 0; ipd <= 1; ipd++)
              for (int tr = 1; tr <= 2; tr++)
                for (int k = 0; k <= 1; k++) begin
                  gdiv = g; kflip = k; s0 = (p1 + p2 + k + g) % 2;
                  build(fc, p1, p2, tr, k, s0);
                  start(fc, p1, ipd, p2, tr);
                  wait_done(400);
                  compare("R3/R5/R6 pulse and sense order");
                  check(done_cnt == 1, "R8 done count", done_cnt, 1);
                  check(!bal_err, "R6 no error on flip", bal_err, 0);
                end

    // R8: train count zero counts as one
    gdiv = 1; kflip = 0; s0 = 1;
    build(0, 1, 1, 0, 0, 1);
    start(0, 1, 0, 1, 0);
    wait_done(200);
    compare("R8 zero train count");
    check(done_cnt == 1, "R8 zero train done", done_cnt, 1);

    // R4: interphase gap in cycles with a grant every cycle
    for (int d = 0; d <= 3; d++) begin
      gdiv = 1; kflip = 0; s0 = 0;
      start(1, 1, d, 1, 1);
      wait_done(200);
      check(ev_n > 1 && ev_cyc[1] - ev_cyc[0] == d + 3, "R4 interphase gap",
            ev_cyc[1] - ev_cyc[0], d + 3);
    end

    // R7: injection cap raises the error and the train still completes
    gdiv = 1; kflip = 1000; s0 = 1;
    build(1, 1, 1, 1, 1000, 1);
    start(1, 1, 0, 1, 1);
    wait_done(3000);
    compare("R7 capped balancing sequence");
    check(bal_err, "R7 error flag", bal_err, 1);
    check(done_cnt == 1, "R7 train completes", done_cnt, 1);
    kflip = 0; s0 = 0;
    start(0, 1, 0, 1, 1);
    wait_done(200);
    check(!bal_err, "R7 error cleared by trigger", bal_err, 0);

    // R10 R1: config change and retrigger during a train
    gdiv = 2; kflip = 0; s0 = 1;
    build(1, 2, 2, 2, 0, 1);
    start(1, 2, 1, 2, 2);
    repeat (3) @(negedge clk);
    cfg_first_cath = 1'b0; cfg_phase1_len = 8'd5; cfg_phase2_len = 8'd0; cfg_trains = 8'd4;
    trigger = 1'b1; @(negedge clk); trigger = 1'b0;
    wait_done(400);
    compare("R10 captured config");
    check(done_cnt == 1, "R1 retrigger ignored", done_cnt, 1);

    // R9: stop while a request is stalled
    gdiv = 0; kflip = 0;
    start(1, 5, 0, 5, 1);
    repeat (4) @(negedge clk);
    check(pulse_req && polarity, "R2 request held while stalled", pulse_req, 1);
    stop = 1'b1; @(negedge clk); stop = 1'b0;
    repeat (3) @(negedge clk);
    check(pulse_req, "R9 outstanding request kept", pulse_req, 1);
    gdiv = 1;
    repeat (10) @(negedge clk);
    check(ev_n == 1, "R9 one pulse after stop", ev_n, 1);
    check(!pulse_req && !sense_req && done_cnt == 0, "R9 idle, no done", done_cnt, 0);

    // R11: request exclusivity seen over the whole run
    check(overlap == 0, "R11 sense and pulse overlap", overlap, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 190000);
    checks = checks + 1;
    errors = errors + 1;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule